// File: doc/BRIEF.md
# Boundary-Aligned DMA Burst Splitter

This block sits in front of a serial flash controller's DMA engine. It accepts one long read or program request: a flash start address, a memory buffer address, a byte count, the opcodes and the read timing settings. It cuts the request into a series of DMA bursts. No burst is longer than `MAX_BURST` bytes, which is 4096 by default. Read bursts are limited only by that maximum. Program bursts are also trimmed so that none of them runs past a `MAX_BURST`-aligned flash address. An unaligned program request therefore starts with a short burst that ends on the next boundary, and every later burst starts on a boundary.

For each burst the block pulses an interrupt-clear strobe. In the next cycle it presents the flash address, memory address, length, dummy-byte count, interface type and a packed command word with the ready bit set. It then waits for the engine's done flag before it prepares the next burst. When the request is finished it pulses a completion strobe and reports the number of bytes moved. If the engine stays silent longer than a programmable number of cycles, the request ends with an error flag and reports the bytes completed up to that point.

Top module: `dma_burst_splitter`

## Requirements
- R1: A read request of N bytes is issued as consecutive bursts of min(remaining, MAX_BURST) bytes. The flash address and the memory address of each burst equal the previous burst's addresses plus the previous burst's length.
- R2: For a program request, each burst length is min(remaining, MAX_BURST - (flash address mod MAX_BURST)). No program burst crosses a MAX_BURST-aligned flash address, and every burst after the first starts aligned.
- R3: The 32-bit command word `burst_cmd` has the following fields:
  - bits [23:16]: the read opcode for a read, otherwise 0.
  - bits [15:8]: the program opcode for a program, otherwise 0.
  - bit 1: the direction (0 = read, 1 = program).
  - bit 0: the ready flag.
  - bits [31:24] and [7:2]: always zero.
- R4: For a read, `burst_dummy` equals the configured dummy clock count divided by 8 (integer division), and `burst_if_type` equals the configured read interface type. For a program, both are 0 (standard interface).
- R5: `int_clear` is high for exactly the one cycle immediately before each cycle in which the ready flag is high.
- R6: The ready flag is high for a single cycle per burst. No further `int_clear` or ready flag appears until `burst_done` has been seen for the current burst.
- R7: A request of length zero issues no burst. `req_done` rises in the cycle after acceptance, with `bytes_moved` = 0 and `req_error` = 0.
- R8: After the last burst's `burst_done`, `req_done` pulses for one cycle. At that point `bytes_moved` equals the request length and `req_error` is 0.
- R9: If `burst_done` is absent for `timeout_limit` consecutive waiting cycles, no further bursts are issued. `req_done` pulses `timeout_limit`+1 cycles after the ready cycle of the stalled burst, with `req_error` = 1 and `bytes_moved` equal to the sum of the completed bursts.
- R10: `req_valid` is accepted only while `req_ready` is high. A request presented while busy is ignored and produces no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = program, 0 = read |
| req_flash_addr | input | FADDR_W | Flash start address |
| req_mem_addr | input | MADDR_W | Memory buffer start address |
| req_len | input | REQ_LEN_W | Request length in bytes |
| rd_opcode | input | 8 | Read opcode |
| wr_opcode | input | 8 | Program opcode |
| rd_dummy_clks | input | DUMMY_CLK_W | Dummy clock cycles for reads |
| rd_if_type | input | 3 | Interface type for reads |
| timeout_limit | input | TIMER_W | Maximum waiting cycles per burst |
| int_clear | output | 1 | Interrupt status clear strobe before each burst |
| burst_cmd | output | 32 | DMA command word, bit 0 = ready |
| burst_flash_addr | output | FADDR_W | Burst flash address |
| burst_mem_addr | output | MADDR_W | Burst memory address |
| burst_len | output | LEN_FIELD_W | Burst length in bytes |
| burst_dummy | output | 4 | Dummy bytes |
| burst_if_type | output | 3 | Interface type |
| burst_done | input | 1 | Operation done from the DMA engine |
| req_done | output | 1 | Request completion strobe |
| req_error | output | 1 | Request ended by timeout |
| bytes_moved | output | REQ_LEN_W | Bytes completed in the request |

## Verification
A wrong remaining count or address register shows up at the very next ready cycle as a burst whose length or address differs from the expected sequence. It also shows up as an extra or missing burst before `req_done`. A wrong boundary computation shows on the first program burst of an unaligned request, and a short first burst followed by misaligned later bursts exposes an error in the advance logic. A timer fault shows as a completion strobe earlier or later than `timeout_limit`+1 cycles after the stalled ready cycle. A skipped state in the clear/issue handshake breaks the one-cycle relation between `int_clear` and the ready flag on the first burst.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } dbs_state_e;

  // command word field positions, decoded by the DMA engine
  localparam int CMD_RDOP_LSB = 16;
  localparam int CMD_WROP_LSB = 8;
  localparam int CMD_DIR_BIT  = 1;
  localparam int CMD_RDY_BIT  = 0;

endpackage

// File: rtl/dbs_chunk_calc.sv
module dbs_chunk_calc #(
  parameter int FADDR_W   = 32,
  parameter int REQ_LEN_W = 24,
  parameter int MAX_BURST = 4096,
  localparam int OFFW     = $clog2(MAX_BURST),
  localparam int BW       = OFFW + 1
) (
  input  logic                 write,
  input  logic [FADDR_W-1:0]   flash_addr,
  input  logic [REQ_LEN_W-1:0] remaining,
  output logic [BW-1:0]        chunk
);

  logic [BW-1:0] room;

  always_comb begin
    if (write) begin
      room = BW'(MAX_BURST) - {1'b0, flash_addr[OFFW-1:0]};
    end else begin
      room = BW'(MAX_BURST);
    end
    if (remaining >= REQ_LEN_W'(room)) begin
      chunk = room;
    end else begin
      chunk = remaining[BW-1:0];
    end
  end

endmodule

// File: rtl/dbs_cmd_pack.sv
module dbs_cmd_pack
  import dbs_pkg::*;
(
  input  logic       write,
  input  logic       ready,
  input  logic [7:0] rd_op,
  input  logic [7:0] wr_op,
  output logic [31:0] cmd
);

  always_comb begin
    cmd = '0;
    if (write) begin
      cmd[CMD_WROP_LSB +: 8] = wr_op;
    end else begin
      cmd[CMD_RDOP_LSB +: 8] = rd_op;
    end
    cmd[CMD_DIR_BIT] = write;
    cmd[CMD_RDY_BIT] = ready;
  end

endmodule

// File: rtl/dbs_timer.sv
module dbs_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               run,
  input  logic [TIMER_W-1:0] limit,
  output logic               expired
);

  logic [TIMER_W-1:0] cnt_q;
  logic [TIMER_W-1:0] cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = clear | run;
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});

endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter
  import dbs_pkg::*;
#(
  parameter int FADDR_W     = 32,
  parameter int MADDR_W     = 32,
  parameter int REQ_LEN_W   = 24,
  parameter int MAX_BURST   = 4096,
  parameter int LEN_FIELD_W = 28,
  parameter int TIMER_W     = 16,
  parameter int DUMMY_CLK_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [FADDR_W-1:0]     req_flash_addr,
  input  logic [MADDR_W-1:0]     req_mem_addr,
  input  logic [REQ_LEN_W-1:0]   req_len,
  input  logic [7:0]             rd_opcode,
  input  logic [7:0]             wr_opcode,
  input  logic [DUMMY_CLK_W-1:0] rd_dummy_clks,
  input  logic [2:0]             rd_if_type,
  input  logic [TIMER_W-1:0]     timeout_limit,
  output logic                   int_clear,
  output logic [31:0]            burst_cmd,
  output logic [FADDR_W-1:0]     burst_flash_addr,
  output logic [MADDR_W-1:0]     burst_mem_addr,
  output logic [LEN_FIELD_W-1:0] burst_len,
  output logic [3:0]             burst_dummy,
  output logic [2:0]             burst_if_type,
  input  logic                   burst_done,
  output logic                   req_done,
  output logic                   req_error,
  output logic [REQ_LEN_W-1:0]   bytes_moved
);

  localparam int OFFW = $clog2(MAX_BURST);
  localparam int BW   = OFFW + 1;

  dbs_state_e             state_q, state_d;
  logic                   write_q, write_d;
  logic [FADDR_W-1:0]     faddr_q, faddr_d;
  logic [MADDR_W-1:0]     maddr_q, maddr_d;
  logic [REQ_LEN_W-1:0]   remain_q, remain_d;
  logic [REQ_LEN_W-1:0]   moved_q, moved_d;
  logic [BW-1:0]          blen_q, blen_d;
  logic [7:0]             rdop_q, rdop_d;
  logic [7:0]             wrop_q, wrop_d;
  logic [3:0]             dummy_q, dummy_d;
  logic [2:0]             ift_q, ift_d;
  logic [TIMER_W-1:0]     limit_q, limit_d;
  logic                   err_q, err_d;
  logic                   dp_en;

  logic [BW-1:0]          chunk;
  logic                   expired;
  logic                   issuing;

  dbs_chunk_calc #(
    .FADDR_W  (FADDR_W),
    .REQ_LEN_W(REQ_LEN_W),
    .MAX_BURST(MAX_BURST)
  ) u_chunk (
    .write     (write_q),
    .flash_addr(faddr_q),
    .remaining (remain_q),
    .chunk     (chunk)
  );

  dbs_timer #(
    .TIMER_W(TIMER_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state_q != ST_WAIT),
    .run    ((state_q == ST_WAIT) && !burst_done),
    .limit  (limit_q),
    .expired(expired)
  );

  assign issuing = (state_q == ST_ISSUE);

  dbs_cmd_pack u_cmd (
    .write(write_q),
    .ready(issuing),
    .rd_op(rdop_q),
    .wr_op(wrop_q),
    .cmd  (burst_cmd)
  );

  // next-state process
  always_comb begin
    state_d  = state_q;
    write_d  = write_q;
    faddr_d  = faddr_q;
    maddr_d  = maddr_q;
    remain_d = remain_q;
    moved_d  = moved_q;
    blen_d   = blen_q;
    rdop_d   = rdop_q;
    wrop_d   = wrop_q;
    dummy_d  = dummy_q;
    ift_d    = ift_q;
    limit_d  = limit_q;
    err_d    = err_q;
    dp_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          dp_en    = 1'b1;
          write_d  = req_write;
          faddr_d  = req_flash_addr;
          maddr_d  = req_mem_addr;
          remain_d = req_len;
          moved_d  = '0;
          rdop_d   = rd_opcode;
          wrop_d   = wr_opcode;
          dummy_d  = req_write ? 4'd0 : 4'(rd_dummy_clks >> 3);
          ift_d    = req_write ? 3'd0 : rd_if_type;
          limit_d  = timeout_limit;
          err_d    = 1'b0;
          state_d  = (req_len == '0) ? ST_FINISH : ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        dp_en   = 1'b1;
        blen_d  = chunk;
        state_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (burst_done) begin
          dp_en    = 1'b1;
          faddr_d  = faddr_q + FADDR_W'(blen_q);
          maddr_d  = maddr_q + MADDR_W'(blen_q);
          remain_d = remain_q - REQ_LEN_W'(blen_q);
          moved_d  = moved_q + REQ_LEN_W'(blen_q);
          state_d  = (remain_q == REQ_LEN_W'(blen_q)) ? ST_FINISH : ST_CLEAR;
        end else if (expired) begin
          dp_en   = 1'b1;
          err_d   = 1'b1;
          state_d = ST_FINISH;
        end
      end
      ST_FINISH: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q  <= 1'b0;
      faddr_q  <= '0;
      maddr_q  <= '0;
      remain_q <= '0;
      moved_q  <= '0;
      blen_q   <= '0;
      rdop_q   <= '0;
      wrop_q   <= '0;
      dummy_q  <= '0;
      ift_q    <= '0;
      limit_q  <= '0;
      err_q    <= 1'b0;
    end else if (dp_en) begin
      write_q  <= write_d;
      faddr_q  <= faddr_d;
      maddr_q  <= maddr_d;
      remain_q <= remain_d;
      moved_q  <= moved_d;
      blen_q   <= blen_d;
      rdop_q   <= rdop_d;
      wrop_q   <= wrop_d;
      dummy_q  <= dummy_d;
      ift_q    <= ift_d;
      limit_q  <= limit_d;
      err_q    <= err_d;
    end
  end

  assign req_ready        = (state_q == ST_IDLE);
  assign int_clear        = (state_q == ST_CLEAR);
  assign req_done         = (state_q == ST_FINISH);
  assign req_error        = err_q;
  assign bytes_moved      = moved_q;
  assign burst_flash_addr = faddr_q;
  assign burst_mem_addr   = maddr_q;
  assign burst_len        = LEN_FIELD_W'(blen_q);
  assign burst_dummy      = dummy_q;
  assign burst_if_type    = ift_q;

  // R1: every issued burst is non-empty and within the maximum
  a_r1_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cmd[CMD_RDY_BIT] |-> (burst_len != '0) && (burst_len <= LEN_FIELD_W'(MAX_BURST)));

  // R2: a program burst never runs past an aligned boundary
  a_r2_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_cmd[CMD_RDY_BIT] && burst_cmd[CMD_DIR_BIT]) |->
      (({1'b0, burst_flash_addr[OFFW-1:0]} + (OFFW+1)'(burst_len)) <= (OFFW+1)'(MAX_BURST)));

  // R5: the clear strobe is followed at once by the ready flag
  a_r5_clear_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    int_clear |=> burst_cmd[CMD_RDY_BIT]);

  // R6: ready lasts one cycle and no new clear follows it directly
  a_r6_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cmd[CMD_RDY_BIT] |=> (!burst_cmd[CMD_RDY_BIT] && !int_clear));

  // R8: a clean completion leaves nothing outstanding
  a_r8_clean_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && !req_error) |-> (remain_q == '0));

  // R10: the block is never idle while a burst is announced
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clear || burst_cmd[CMD_RDY_BIT] || req_done) |-> !req_ready);

endmodule

// File: tb/dma_burst_splitter_test.sv
module dma_burst_splitter_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [31:0] req_flash_addr;
  logic [31:0] req_mem_addr;
  logic [23:0] req_len;
  logic [7:0]  rd_opcode;
  logic [7:0]  wr_opcode;
  logic [6:0]  rd_dummy_clks;
  logic [2:0]  rd_if_type;
  logic [15:0] timeout_limit;
  logic        int_clear;
  logic [31:0] burst_cmd;
  logic [31:0] burst_flash_addr;
  logic [31:0] burst_mem_addr;
  logic [27:0] burst_len;
  logic [3:0]  burst_dummy;
  logic [2:0]  burst_if_type;
  logic        burst_done;
  logic        req_done;
  logic        req_error;
  logic [23:0] bytes_moved;

  dma_burst_splitter uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_write       (req_write),
    .req_flash_addr  (req_flash_addr),
    .req_mem_addr    (req_mem_addr),
    .req_len         (req_len),
    .rd_opcode       (rd_opcode),
    .wr_opcode       (wr_opcode),
    .rd_dummy_clks   (rd_dummy_clks),
    .rd_if_type      (rd_if_type),
    .timeout_limit   (timeout_limit),
    .int_clear       (int_clear),
    .burst_cmd       (burst_cmd),
    .burst_flash_addr(burst_flash_addr),
    .burst_mem_addr  (burst_mem_addr),
    .burst_len       (burst_len),
    .burst_dummy     (burst_dummy),
    .burst_if_type   (burst_if_type),
    .burst_done      (burst_done),
    .req_done        (req_done),
    .req_error       (req_error),
    .bytes_moved     (bytes_moved)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [31:0] fa;
    logic [31:0] ma;
    logic [27:0] len;
    logic [31:0] cmd;
    logic [3:0]  dum;
    logic [2:0]  ift;
  } exp_t;

  exp_t exp_q[$];
  int   tests;
  int   fails;
  int   cyc;
  int   last_issue_cyc;
  int   burst_idx;
  int   budget;
  logic prev_clear;
  logic resp_pending;
  int   resp_cnt;
  bit   finished;

  always @(negedge clk) cyc <= cyc + 1;

  // monitor and DMA engine responder
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_clear   <= 1'b0;
      resp_pending <= 1'b0;
      burst_done   <= 1'b0;
    end else begin
      burst_done <= 1'b0;
      if (resp_pending) begin
        if (resp_cnt == 0) begin
          burst_done   <= 1'b1;
          resp_pending <= 1'b0;
        end else begin
          resp_cnt <= resp_cnt - 1;
        end
      end
      if (burst_cmd[0]) begin
        tests++;
        if (prev_clear !== 1'b1) begin
          fails++;
          $display("FAIL R5: int_clear before ready act=%b exp=1", prev_clear);
        end
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R10: unexpected burst act fa=%h len=%0d exp none",
                   burst_flash_addr, burst_len);
        end else begin
          exp_t e;
          exp_t a;
          e = exp_q.pop_front();
          a = '{burst_flash_addr, burst_mem_addr, burst_len, burst_cmd,
                burst_dummy, burst_if_type};
          if (a !== e) begin
            fails++;
            $display("FAIL R1/R2/R3/R4: burst act fa=%h ma=%h len=%0d cmd=%h d=%0d t=%0d exp fa=%h ma=%h len=%0d cmd=%h d=%0d t=%0d",
                     a.fa, a.ma, a.len, a.cmd, a.dum, a.ift,
                     e.fa, e.ma, e.len, e.cmd, e.dum, e.ift);
          end
        end
        last_issue_cyc <= cyc;
        if (budget != 0) begin
          resp_pending <= 1'b1;
          resp_cnt     <= burst_idx % 3;
          if (budget > 0) budget <= budget - 1;
        end
        burst_idx <= burst_idx + 1;
      end
      prev_clear <= int_clear;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // driver: pushes expected bursts, then runs the request
  task automatic run_req(input bit wr, input int fa, input int ma, input int len,
                         input int n_ok, input int limit, input bit poke);
    int   rem;
    int   f;
    int   m;
    int   nb;
    int   moved;
    int   room;
    int   b;
    bit   exp_err;
    exp_t e;
    rem = len; f = fa; m = ma; nb = 0; moved = 0; exp_err = 1'b0;
    while (rem > 0) begin
      room = wr ? (4096 - (f % 4096)) : 4096;
      b = (rem < room) ? rem : room;
      if (n_ok >= 0 && nb > n_ok) break;
      e.fa  = f; e.ma = m; e.len = b;
      e.cmd = wr ? {8'h00, 8'h00, wr_opcode, 6'b0, 1'b1, 1'b1}
                 : {8'h00, rd_opcode, 8'h00, 6'b0, 1'b0, 1'b1};
      e.dum = wr ? 4'd0 : 4'(rd_dummy_clks >> 3);
      e.ift = wr ? 3'd0 : rd_if_type;
      exp_q.push_back(e);
      if (n_ok < 0 || nb < n_ok) moved += b;
      else exp_err = 1'b1;
      f += b; m += b; rem -= b; nb++;
    end
    budget = n_ok;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_flash_addr = fa; req_mem_addr = ma;
    req_len = len; timeout_limit = 16'(limit);
    @(negedge clk);
    if (len == 0) begin
      check(req_done === 1'b1, "R7: zero length done next cycle", int'(req_done), 1);
    end
    if (poke) begin
      req_write = ~wr; req_flash_addr = 32'h0000_0010; req_len = 24'd77;
      @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (req_done !== 1'b1) @(negedge clk);
    check(req_error === exp_err, "R8/R9: req_error", int'(req_error), int'(exp_err));
    check(int'(bytes_moved) == moved, "R8/R9: bytes_moved", int'(bytes_moved), moved);
    check(exp_q.size() == 0, "R6/R9: bursts missing at done", exp_q.size(), 0);
    if (exp_err) begin
      check(cyc - last_issue_cyc == limit + 1, "R9: timeout delay",
            cyc - last_issue_cyc, limit + 1);
    end
    exp_q.delete();
    @(negedge clk);
  endtask

  initial begin
    tests = 0; fails = 0; cyc = 0; burst_idx = 0; budget = -1;
    last_issue_cyc = 0; finished = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_flash_addr = '0; req_mem_addr = '0; req_len = '0;
    rd_opcode = 8'h6B; wr_opcode = 8'h32; rd_dummy_clks = 7'd16;
    rd_if_type = 3'd3; timeout_limit = 16'd100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, "reset: req_ready", int'(req_ready), 1);
    check(burst_cmd[0] === 1'b0 && int_clear === 1'b0, "reset: no burst",
          int'(burst_cmd[0]), 0);
    check(req_done === 1'b0 && bytes_moved === 24'd0, "reset: no done",
          int'(req_done), 0);

    // R1 R3 R4: read, split by maximum length only
    run_req(1'b0, 32'h0000_0000, 32'h8000_0000, 10000, -1, 100, 1'b0);
    // R1: unaligned read crosses a boundary freely
    rd_dummy_clks = 7'd8; rd_if_type = 3'd1;
    run_req(1'b0, 32'h0000_0010, 32'h8000_4000, 5000, -1, 100, 1'b0);
    // R2: unaligned program trimmed to boundaries
    run_req(1'b1, 32'h0000_1F00, 32'h9000_0000, 9000, -1, 100, 1'b0);
    // R2: one byte below a boundary, then aligned remainder
    run_req(1'b1, 32'h0000_0FFF, 32'h9000_1000, 5, -1, 100, 1'b0);
    // R2: aligned full-size program
    run_req(1'b1, 32'h0000_3000, 32'h9000_2000, 4096, -1, 100, 1'b0);
    // R7: zero length
    run_req(1'b0, 32'h0000_0100, 32'h8000_0000, 0, -1, 100, 1'b0);
    // R10: new request offered while busy is ignored
    rd_dummy_clks = 7'd31; rd_if_type = 3'd4;
    run_req(1'b0, 32'h0001_0000, 32'hA000_0000, 8200, -1, 100, 1'b1);
    // R9: second burst never completes
    run_req(1'b0, 32'h0002_0000, 32'hB000_0000, 6000, 1, 20, 1'b0);
    // R8: normal operation after a timeout
    run_req(1'b1, 32'h0002_0800, 32'hB000_8000, 3000, -1, 100, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run hung act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule